// File: doc/BRIEF.md
# ADC Command Control Register

This block is the command register of an analog-to-digital converter, placed on a simple 32-bit register bus. Software writes 1 to command bits to ask for calibration, enabling, disabling, starting or stopping a conversion. The block passes each accepted command to the converter core as a one-cycle request pulse. The bit then stays at 1 until the core returns the matching done pulse. A voltage-regulator enable bit is an ordinary read/write bit. A programmable startup counter stands between setting that bit and the converter accepting work.

Every write is screened against the commands already pending. A request that the current state does not permit is dropped without any side effect. When one write carries several requests, they are resolved in a fixed order. Any request that conflicts with one accepted earlier in that order is dropped. The block also gates an external write strobe for the calibration-factor register so that it passes only while the converter is enabled and idle.

Top module: `adc_cmd_ctrl`

## Requirements
- R1: Out of reset every register bit is 0. Only offset 0x08 returns the register; any other offset reads 0. Bits 31 (calibrate), 28 (regulator), 4 (stop), 2 (start), 1 (disable) and 0 (enable) are live, and every other bit reads 0.
- R2: A write with bit 31 set starts calibration only when calibrate, start, stop, disable and enable are all 0, `auto_off` is 0 and the regulator is ready. Bit 31 then reads 1 until `done_cal`, and no other command bit is set while it is 1.
- R3: Bit 28 takes the written value only when calibrate, start, stop, disable and enable are all 0 before the write and no command is accepted by that write. Otherwise the bit keeps its value, so it cannot be cleared while enable is 1.
- R4: `vreg_ready` rises once bit 28 has been 1 for `stup_cycles` clock edges. Enable and calibrate requests are ignored until it is 1. Clearing bit 28 drops `vreg_ready` and restarts the count.
- R5: Enable (bit 0) is set-only. It is accepted when enable, calibrate and disable are 0 and the regulator is ready. Writing 0 leaves it unchanged.
- R6: Start (bit 2) is accepted only when enable is 1 and start, stop, disable and calibrate are 0. `done_start` clears it unless a stop is pending.
- R7: Stop (bit 4) is accepted only when start is 1 and stop and disable are 0. `done_stop` clears both stop and start.
- R8: Disable (bit 1) is accepted only when enable is 1 and start and disable are 0. `done_dis` clears both disable and enable.
- R9: Within one write, requests are considered in the order disable, stop, calibrate, enable, start. Once any command has been accepted, every request later in that order is dropped.
- R10: `calf_wr_en` follows `calf_wr_req` only while enable is 1 and start is 0, and is 0 otherwise.
- R11: Each accepted command gives a single-cycle pulse on its `req_*` output in the cycle after the write. At most one request pulse is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 32 | Read data |
| auto_off | input | 1 | Auto-off mode flag from configuration; blocks calibration |
| stup_cycles | input | STUP_W | Regulator startup delay in cycles |
| done_cal | input | 1 | Core: calibration finished |
| done_start | input | 1 | Core: conversion finished |
| done_stop | input | 1 | Core: conversion discarded |
| done_dis | input | 1 | Core: converter disabled |
| req_cal | output | 1 | Calibrate request pulse |
| req_en | output | 1 | Enable request pulse |
| req_start | output | 1 | Start request pulse |
| req_stop | output | 1 | Stop request pulse |
| req_dis | output | 1 | Disable request pulse |
| vreg_ready | output | 1 | Regulator startup complete |
| calf_wr_req | input | 1 | Raw write strobe for the calibration factor |
| calf_wr_en | output | 1 | Gated calibration-factor write strobe |

## Verification
The assertions check the state invariants on every cycle. Calibration excludes every other command. A pending stop implies a pending start, and start implies enable. At most one request pulse is high at a time, an enable request is never issued before the regulator is ready, and the regulator bit changes only from the fully idle state. The bench's scenarios, checked against a behavioural model, show the rest: the ordering of multi-bit writes, the rejected writes, done pulses that arrive in the wrong state, the length of the startup count, and the calibration-factor gate.

// File: rtl/adc_cmd_pkg.sv
package adc_cmd_pkg;
  localparam int BIT_CAL   = 31;
  localparam int BIT_VREG  = 28;
  localparam int BIT_STOP  = 4;
  localparam int BIT_START = 2;
  localparam int BIT_DIS   = 1;
  localparam int BIT_EN    = 0;

  typedef struct packed {
    logic cal;
    logic stop;
    logic start;
    logic dis;
    logic en;
  } cmd_t;
endpackage

// File: rtl/adc_vreg_timer.sv
module adc_vreg_timer #(
  parameter int STUP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vreg_on,
  input  logic [STUP_W-1:0] stup_cycles,
  output logic              ready
);
  logic [STUP_W-1:0] cnt_q, cnt_d;
  logic              cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!vreg_on) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (cnt_q < stup_cycles) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign ready = vreg_on && (cnt_q >= stup_cycles);

  // R4: the count restarts from zero whenever the regulator is off
  assert_cnt_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !vreg_on |=> (cnt_q == '0));
endmodule

// File: rtl/adc_cmd_arbiter.sv
module adc_cmd_arbiter
  import adc_cmd_pkg::*;
(
  input  cmd_t cur,
  input  logic vreg_rdy,
  input  logic auto_off,
  input  logic wr,
  input  cmd_t wreq,
  output cmd_t acc,
  output logic vreg_upd
);
  logic idle;

  assign idle = (cur == '0);

  // Fixed resolution order: disable, stop, calibrate, enable, start (R9)
  always_comb begin
    acc      = '0;
    vreg_upd = 1'b0;
    if (wr) begin
      if (wreq.dis && cur.en && !cur.start && !cur.dis)
        acc.dis = 1'b1;
      if (wreq.stop && cur.start && !cur.stop && !cur.dis && !acc.dis)
        acc.stop = 1'b1;
      if (wreq.cal && idle && !auto_off && vreg_rdy && !acc.dis && !acc.stop)
        acc.cal = 1'b1;
      if (wreq.en && !cur.en && !cur.cal && !cur.dis && vreg_rdy &&
          !acc.dis && !acc.stop && !acc.cal)
        acc.en = 1'b1;
      if (wreq.start && cur.en && !cur.start && !cur.stop && !cur.dis &&
          !cur.cal && (acc == '0))
        acc.start = 1'b1;
      vreg_upd = idle && (acc == '0);
    end
  end
endmodule

// File: rtl/adc_cmd_ctrl.sv
module adc_cmd_ctrl
  import adc_cmd_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter int                STUP_W    = 8,
  parameter logic [ADDR_W-1:0] CR_OFFSET = 'h08
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  output logic [31:0]       bus_rdata,
  input  logic              auto_off,
  input  logic [STUP_W-1:0] stup_cycles,
  input  logic              done_cal,
  input  logic              done_start,
  input  logic              done_stop,
  input  logic              done_dis,
  output logic              req_cal,
  output logic              req_en,
  output logic              req_start,
  output logic              req_stop,
  output logic              req_dis,
  output logic              vreg_ready,
  input  logic              calf_wr_req,
  output logic              calf_wr_en
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_n_s;
  cmd_t                   cmd_q, cmd_d, acc, clr, wreq, req_q;
  logic                   vreg_q, vreg_d, vreg_upd, wr_hit, vreg_en;
  logic                   unused_wbits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[SYNC_STAGES-1];

  assign wr_hit     = bus_we && (bus_addr == CR_OFFSET);
  assign wreq.cal   = bus_wdata[BIT_CAL];
  assign wreq.stop  = bus_wdata[BIT_STOP];
  assign wreq.start = bus_wdata[BIT_START];
  assign wreq.dis   = bus_wdata[BIT_DIS];
  assign wreq.en    = bus_wdata[BIT_EN];
  assign unused_wbits = ^{bus_wdata[30:29], bus_wdata[27:5], bus_wdata[3]};

  adc_vreg_timer #(.STUP_W(STUP_W)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .vreg_on     (vreg_q),
    .stup_cycles (stup_cycles),
    .ready       (vreg_ready)
  );

  adc_cmd_arbiter u_arb (
    .cur      (cmd_q),
    .vreg_rdy (vreg_ready),
    .auto_off (auto_off),
    .wr       (wr_hit),
    .wreq     (wreq),
    .acc      (acc),
    .vreg_upd (vreg_upd)
  );

  // Hardware clears from the core's done pulses, ignored in the wrong state
  always_comb begin
    clr       = '0;
    clr.cal   = done_cal && cmd_q.cal;
    clr.stop  = done_stop && cmd_q.stop;
    clr.start = (done_stop && cmd_q.stop) || (done_start && cmd_q.start && !cmd_q.stop);
    clr.dis   = done_dis && cmd_q.dis;
    clr.en    = done_dis && cmd_q.dis;
    cmd_d     = (cmd_q & ~clr) | acc;
    vreg_en   = vreg_upd && (vreg_q != bus_wdata[BIT_VREG]);
    vreg_d    = bus_wdata[BIT_VREG];
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      cmd_q <= '0;
      req_q <= '0;
    end else begin
      cmd_q <= cmd_d;
      req_q <= acc;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)     vreg_q <= 1'b0;
    else if (vreg_en) vreg_q <= vreg_d;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == CR_OFFSET) begin
      bus_rdata[BIT_CAL]   = cmd_q.cal;
      bus_rdata[BIT_VREG]  = vreg_q;
      bus_rdata[BIT_STOP]  = cmd_q.stop;
      bus_rdata[BIT_START] = cmd_q.start;
      bus_rdata[BIT_DIS]   = cmd_q.dis;
      bus_rdata[BIT_EN]    = cmd_q.en;
    end
  end

  assign req_cal    = req_q.cal;
  assign req_en     = req_q.en;
  assign req_start  = req_q.start;
  assign req_stop   = req_q.stop;
  assign req_dis    = req_q.dis;
  assign calf_wr_en = calf_wr_req && cmd_q.en && !cmd_q.start;

  assert_req_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0({req_cal, req_en, req_start, req_stop, req_dis}));
  assert_cal_alone_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    cmd_q.cal |-> !(cmd_q.en || cmd_q.start || cmd_q.stop || cmd_q.dis));
  assert_stop_needs_start_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    cmd_q.stop |-> cmd_q.start);
  assert_start_needs_en_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    cmd_q.start |-> cmd_q.en);
  assert_en_after_ready_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    req_en |-> $past(vreg_ready));
  assert_vreg_idle_only_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (vreg_q != $past(vreg_q)) |-> ($past(cmd_q) == '0));
endmodule

// File: tb/adc_cmd_ctrl_bench.sv
module adc_cmd_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = 8'h08;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic        auto_off = 1'b0;
  logic [7:0]  stup_cycles = 8'd4;
  logic        done_cal = 1'b0, done_start = 1'b0, done_stop = 1'b0, done_dis = 1'b0;
  logic        req_cal, req_en, req_start, req_stop, req_dis, vreg_ready;
  logic        calf_wr_req = 1'b1;
  logic        calf_wr_en;

  int    n_cmp = 0;
  int    n_bad = 0;
  string cur_tag = "R1";

  // behavioural reference state
  bit m_cal, m_vreg, m_stop, m_start, m_dis, m_en;
  bit p_cal, p_en, p_start, p_stop, p_dis;
  int m_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_cmd_ctrl u_adc_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .auto_off(auto_off),
    .stup_cycles(stup_cycles), .done_cal(done_cal), .done_start(done_start),
    .done_stop(done_stop), .done_dis(done_dis), .req_cal(req_cal),
    .req_en(req_en), .req_start(req_start), .req_stop(req_stop),
    .req_dis(req_dis), .vreg_ready(vreg_ready), .calf_wr_req(calf_wr_req),
    .calf_wr_en(calf_wr_en)
  );

  function automatic bit model_ready();
    return m_vreg && (m_cnt >= int'(stup_cycles));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_cal, m_vreg, m_stop, m_start, m_dis, m_en} = '0;
      {p_cal, p_en, p_start, p_stop, p_dis} = '0;
      m_cnt = 0;
    end else begin
      bit taken, idle, rdy, nvreg;
      bit a_cal, a_en, a_start, a_stop, a_dis;
      {a_cal, a_en, a_start, a_stop, a_dis} = '0;
      taken = 0;
      idle  = !(m_cal || m_stop || m_start || m_dis || m_en);
      rdy   = model_ready();
      nvreg = m_vreg;
      if (bus_we && bus_addr == 8'h08) begin
        if (bus_wdata[1] && m_en && !m_start && !m_dis) begin a_dis = 1; taken = 1; end
        if (!taken && bus_wdata[4] && m_start && !m_stop && !m_dis) begin a_stop = 1; taken = 1; end
        if (!taken && bus_wdata[31] && idle && !auto_off && rdy) begin a_cal = 1; taken = 1; end
        if (!taken && bus_wdata[0] && !m_en && !m_cal && !m_dis && rdy) begin a_en = 1; taken = 1; end
        if (!taken && bus_wdata[2] && m_en && !m_start && !m_stop && !m_dis && !m_cal) begin
          a_start = 1; taken = 1;
        end
        if (idle && !taken) nvreg = bus_wdata[28];
      end
      if (!m_vreg) m_cnt = 0;
      else if (m_cnt < int'(stup_cycles)) m_cnt++;
      if (done_cal) m_cal = 0;
      if (done_stop && m_stop) begin m_stop = 0; m_start = 0; end
      else if (done_start && !m_stop) m_start = 0;
      if (done_dis && m_dis) begin m_dis = 0; m_en = 0; end
      m_cal = m_cal | a_cal; m_en = m_en | a_en; m_start = m_start | a_start;
      m_stop = m_stop | a_stop; m_dis = m_dis | a_dis; m_vreg = nvreg;
      {p_cal, p_en, p_start, p_stop, p_dis} = {a_cal, a_en, a_start, a_stop, a_dis};
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #(CLK_PERIOD/4);
    if (rst_n) begin
      logic [31:0] exp_rd;
      exp_rd = '0;
      if (bus_addr == 8'h08)
        exp_rd = {m_cal, 2'b00, m_vreg, 23'd0, m_stop, 1'b0, m_start, m_dis, m_en};
      chk(cur_tag, "rdata", bus_rdata, exp_rd);
      chk("R2",  "req_cal",   {31'd0, req_cal},   {31'd0, p_cal});
      chk("R5",  "req_en",    {31'd0, req_en},    {31'd0, p_en});
      chk("R6",  "req_start", {31'd0, req_start}, {31'd0, p_start});
      chk("R7",  "req_stop",  {31'd0, req_stop},  {31'd0, p_stop});
      chk("R8",  "req_dis",   {31'd0, req_dis},   {31'd0, p_dis});
      chk("R4",  "vreg_ready", {31'd0, vreg_ready}, {31'd0, model_ready()});
      chk("R10", "calf_wr_en", {31'd0, calf_wr_en}, {31'd0, calf_wr_req && m_en && !m_start});
      chk("R11", "req count", $countones({req_cal, req_en, req_start, req_stop, req_dis}) > 1, 0);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 8'h08;
    cyc(1);
  endtask

  task automatic done_pulse(input int which);
    @(negedge clk);
    case (which)
      0: done_cal = 1'b1;
      1: done_start = 1'b1;
      2: done_stop = 1'b1;
      default: done_dis = 1'b1;
    endcase
    @(negedge clk);
    {done_cal, done_start, done_stop, done_dis} = '0;
    cyc(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(5);
    // R1: reset contents, other offset reads zero
    cur_tag = "R1";
    @(negedge clk); bus_addr = 8'h0C;
    cyc(2); bus_addr = 8'h08;
    wr(8'h0C, 32'hFFFF_FFFF);
    // R4: enable before regulator, then before startup expires
    cur_tag = "R4";
    wr(8'h08, 32'h0000_0001);
    wr(8'h08, 32'h1000_0000);
    wr(8'h08, 32'h8000_0001);
    cyc(6);
    // R2: auto-off blocks calibration, then calibration runs
    cur_tag = "R2";
    auto_off = 1'b1;
    wr(8'h08, 32'h9000_0000);
    auto_off = 1'b0;
    wr(8'h08, 32'h9000_0000);
    // R3: regulator cannot be cleared while calibrating
    cur_tag = "R3";
    wr(8'h08, 32'h0000_0000);
    cur_tag = "R2";
    done_pulse(0);
    // R9: calibrate wins over enable and start in one write
    cur_tag = "R9";
    wr(8'h08, 32'h9000_0005);
    done_pulse(0);
    wr(8'h08, 32'h1000_0005);
    // R5: writing zero leaves enable set
    cur_tag = "R5";
    wr(8'h08, 32'h1000_0000);
    cur_tag = "R3";
    wr(8'h08, 32'h0000_0000);
    // R6: start, disable refused while converting, done clears start
    cur_tag = "R6";
    wr(8'h08, 32'h0000_0004);
    wr(8'h08, 32'h0000_0002);
    done_pulse(1);
    wr(8'h08, 32'h0000_0004);
    // R7: stop, a stray conversion-done is ignored, stop completion
    cur_tag = "R7";
    wr(8'h08, 32'h0000_0010);
    done_pulse(1);
    done_pulse(2);
    done_pulse(2);
    // R9 and R8: all bits at once gives disable only
    cur_tag = "R9";
    wr(8'h08, 32'h9000_0017);
    cur_tag = "R8";
    wr(8'h08, 32'h0000_0004);
    done_pulse(3);
    // R3: regulator clear accepted once idle, ready drops
    cur_tag = "R3";
    wr(8'h08, 32'h0000_0000);
    cur_tag = "R4";
    wr(8'h08, 32'h0000_0001);
    stup_cycles = 8'd0;
    wr(8'h08, 32'h1000_0000);
    wr(8'h08, 32'h1000_0001);
    cyc(4);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule